// File: doc/BRIEF.md
# Core State Address Decoder

This block sits between the load/store path of a small 8-bit core and the rest of its data space. Each cycle it accepts at most one single-byte access and decides where it goes. The first 32 data addresses reach the general register file, which lives outside this block and is driven through a dedicated port. Eight consecutive data addresses, 0x58 to 0x5F, form a window onto core state that this block holds itself. That state is four address-page extension registers, an indirect-jump extension register, the two halves of the stack pointer and the eight status flags. Every other address is forwarded to an external data-memory port, offset by a fixed data-space base.

Feature-enable inputs state which optional registers exist on a given core variant. A store to a register whose feature is off is dropped without any other effect. The extension registers are kept in their shifted form, with the written byte at the top of a wider field, so the address generator can use them directly. Read data comes back one cycle after the request for every target.

Top module: `core_reg_mapper`

## Requirements
- R1: An access to data address 0 to 31 asserts `gpr_en`, with `gpr_addr` equal to the low five address bits and `gpr_we`/`gpr_wdata` copied from the request, in the same cycle. `ext_en` stays low.
- R2: A read from data address 0 to 31 returns, on `rd_data` one cycle later, the byte the register file presents on `gpr_rdata`.
- R3: A store to 0x58, 0x59, 0x5A or 0x5B writes page register 0, 1, 2 or 3 when `page_en` bit 0, 1, 2 or 3 is set. The byte lands in bits 23:16 of the 24-bit register and the lower 16 bits are zero. Page register k occupies `page_bank[24k+23:24k]`. A read of the same address returns bits 23:16.
- R4: A store to a page register whose `page_en` bit is clear leaves that register unchanged.
- R5: A store to 0x5C always writes the jump-extension register, with the byte in bits 23:16. A read of 0x5C returns that byte.
- R6: A store to 0x5D replaces stack pointer bits 7:0 and keeps bits 15:8.
- R7: A store to 0x5E replaces stack pointer bits 15:8 only when `wide_sp_en` is 1. With `wide_sp_en` at 0 the stack pointer is unchanged. A read of 0x5D or 0x5E returns the low or high stack pointer byte.
- R8: A store to 0x5F loads all eight status flags at once. A read of 0x5F returns them as one byte, with flag i in bit i.
- R9: An access to any other address, including 0x20 to 0x57 and 0x60 upward, asserts `ext_en` in the same cycle. It drives `ext_addr` = `DATA_BASE` + address, with the write enable and data copied through, and leaves `gpr_en` low. A read returns `ext_rdata` one cycle later.
- R10: While `rst` is high, all held state (page, jump-extension, stack pointer and status registers) clears to zero and `rd_valid` is low.
- R11: `rd_valid` is high in exactly the cycle after each read request. It stays low after stores and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = store, 0 = load |
| acc_addr | input | AW (16) | Data-space byte address |
| acc_wdata | input | 8 | Store byte |
| rd_data | output | 8 | Load result, valid when rd_valid |
| rd_valid | output | 1 | Load result strobe |
| page_en | input | 4 | Feature enables for page registers 0..3 |
| wide_sp_en | input | 1 | Enables the stack pointer high byte |
| gpr_en | output | 1 | Register file access strobe |
| gpr_we | output | 1 | Register file write enable |
| gpr_addr | output | 5 | Register index |
| gpr_wdata | output | 8 | Register write byte |
| gpr_rdata | input | 8 | Register file read byte, one cycle after gpr_en |
| ext_en | output | 1 | External memory access strobe |
| ext_we | output | 1 | External memory write enable |
| ext_addr | output | EXT_AW (24) | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte, one cycle after ext_en |
| page_bank | output | 4*PAGE_W (96) | The four page registers, register 0 lowest |
| jump_ext | output | PAGE_W (24) | Jump-extension register |
| sp_val | output | 16 | Stack pointer |
| status_flags | output | 8 | Status flags |

## Verification
The steering outputs (`gpr_*`, `ext_*`) are combinational from the request, so the bench checks them shortly after it drives a request and before the next clock edge. Stores to held state take effect at the edge that samples the request. The bench therefore reads `page_bank`, `jump_ext`, `sp_val` and `status_flags` at the following falling edge. Load data and `rd_valid` are due exactly one cycle after the request, so every access task drives on a falling edge and samples one full cycle later, on the next falling edge. One further falling edge is used to confirm that `rd_valid` has dropped again.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  typedef enum logic [1:0] {TGT_GPR = 2'd0, TGT_SPEC = 2'd1, TGT_EXT = 2'd2} tgt_e;

  localparam int GPR_COUNT  = 32;
  localparam int SPEC_BASE  = 'h58;   // I/O offset 0x38 plus the 32 register slots
  localparam int SPEC_COUNT = 8;
  localparam int PAGE_COUNT = 4;

  // window slot order, shared by the decoder and the state bank
  localparam logic [2:0] SLOT_JUMP   = 3'd4;
  localparam logic [2:0] SLOT_SP_LO  = 3'd5;
  localparam logic [2:0] SLOT_SP_HI  = 3'd6;
  localparam logic [2:0] SLOT_STATUS = 3'd7;
endpackage

// File: rtl/cmap_decode.sv
module cmap_decode
  import cmap_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          EXT_AW    = 24,
  parameter int unsigned DATA_BASE = 'h10000
) (
  input  logic [AW-1:0]     addr,
  output tgt_e              tgt,
  output logic [2:0]        slot,
  output logic [EXT_AW-1:0] ext_addr
);
  localparam logic [AW-1:0] GPR_END  = AW'(GPR_COUNT);
  localparam logic [AW-1:0] WIN_LO   = AW'(SPEC_BASE);
  localparam logic [AW-1:0] WIN_HI   = AW'(SPEC_BASE + SPEC_COUNT);

  always_comb begin
    if (addr < GPR_END)                       tgt = TGT_GPR;
    else if (addr >= WIN_LO && addr < WIN_HI) tgt = TGT_SPEC;
    else                                      tgt = TGT_EXT;
  end

  assign slot     = addr[2:0];
  assign ext_addr = EXT_AW'(DATA_BASE) + EXT_AW'(addr);
endmodule

// File: rtl/cmap_state.sv
module cmap_state
  import cmap_pkg::*;
#(
  parameter int PAGE_W = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [2:0]                   slot,
  input  logic [7:0]                   wdata,
  input  logic [PAGE_COUNT-1:0]        page_en,
  input  logic                         wide_sp_en,
  output logic [PAGE_COUNT*PAGE_W-1:0] page_bank,
  output logic [PAGE_W-1:0]            jump_ext,
  output logic [15:0]                  sp_val,
  output logic [7:0]                   status_flags,
  output logic [7:0]                   rd_byte
);
  localparam int LSB_W = PAGE_W - 8;

  for (genvar g = 0; g < PAGE_COUNT; g++) begin : g_page
    logic [PAGE_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)
        r <= '0;
      else if (wr && slot == 3'(g) && page_en[g])
        r <= {wdata, {LSB_W{1'b0}}};
    end
    assign page_bank[g*PAGE_W +: PAGE_W] = r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      jump_ext     <= '0;
      sp_val       <= '0;
      status_flags <= '0;
    end else if (wr) begin
      case (slot)
        SLOT_JUMP:   jump_ext     <= {wdata, {LSB_W{1'b0}}};
        SLOT_SP_LO:  sp_val[7:0]  <= wdata;
        SLOT_SP_HI:  if (wide_sp_en) sp_val[15:8] <= wdata;
        SLOT_STATUS: status_flags <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (slot)
      SLOT_JUMP:   rd_byte = jump_ext[PAGE_W-1 -: 8];
      SLOT_SP_LO:  rd_byte = sp_val[7:0];
      SLOT_SP_HI:  rd_byte = sp_val[15:8];
      SLOT_STATUS: rd_byte = status_flags;
      default:     rd_byte = page_bank[32'(slot[1:0])*PAGE_W + LSB_W +: 8];
    endcase
  end
endmodule

// File: rtl/core_reg_mapper.sv
module core_reg_mapper
  import cmap_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          EXT_AW    = 24,
  parameter int          PAGE_W    = 24,
  parameter int unsigned DATA_BASE = 'h10000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc_valid,
  input  logic                         acc_we,
  input  logic [AW-1:0]                acc_addr,
  input  logic [7:0]                   acc_wdata,
  output logic [7:0]                   rd_data,
  output logic                         rd_valid,
  input  logic [3:0]                   page_en,
  input  logic                         wide_sp_en,
  output logic                         gpr_en,
  output logic                         gpr_we,
  output logic [4:0]                   gpr_addr,
  output logic [7:0]                   gpr_wdata,
  input  logic [7:0]                   gpr_rdata,
  output logic                         ext_en,
  output logic                         ext_we,
  output logic [EXT_AW-1:0]            ext_addr,
  output logic [7:0]                   ext_wdata,
  input  logic [7:0]                   ext_rdata,
  output logic [4*PAGE_W-1:0]          page_bank,
  output logic [PAGE_W-1:0]            jump_ext,
  output logic [15:0]                  sp_val,
  output logic [7:0]                   status_flags
);
  tgt_e       tgt;
  tgt_e       sel_q;
  logic [2:0] slot;
  logic [7:0] spec_byte;
  logic [7:0] spec_q;
  logic       is_read;

  cmap_decode #(.AW(AW), .EXT_AW(EXT_AW), .DATA_BASE(DATA_BASE)) u_dec (
    .addr(acc_addr), .tgt(tgt), .slot(slot), .ext_addr(ext_addr)
  );

  cmap_state #(.PAGE_W(PAGE_W)) u_state (
    .clk(clk), .rst(rst),
    .wr(acc_valid && acc_we && tgt == TGT_SPEC),
    .slot(slot), .wdata(acc_wdata),
    .page_en(page_en), .wide_sp_en(wide_sp_en),
    .page_bank(page_bank), .jump_ext(jump_ext),
    .sp_val(sp_val), .status_flags(status_flags),
    .rd_byte(spec_byte)
  );

  assign gpr_en    = acc_valid && tgt == TGT_GPR;
  assign gpr_we    = acc_we;
  assign gpr_addr  = acc_addr[4:0];
  assign gpr_wdata = acc_wdata;

  assign ext_en    = acc_valid && tgt == TGT_EXT;
  assign ext_we    = acc_we;
  assign ext_wdata = acc_wdata;

  assign is_read = acc_valid && !acc_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_q    <= TGT_GPR;
      spec_q   <= '0;
    end else begin
      rd_valid <= is_read;
      if (is_read) begin
        sel_q  <= tgt;
        spec_q <= spec_byte;
      end
    end
  end

  always_comb begin
    case (sel_q)
      TGT_GPR:  rd_data = gpr_rdata;
      TGT_SPEC: rd_data = spec_q;
      default:  rd_data = ext_rdata;
    endcase
  end
endmodule

// File: rtl/cmap_chk.sv
module cmap_chk #(
  parameter int          AW        = 16,
  parameter int          EXT_AW    = 24,
  parameter int          PAGE_W    = 24,
  parameter int unsigned DATA_BASE = 'h10000
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic                acc_we,
  input logic [AW-1:0]       acc_addr,
  input logic                rd_valid,
  input logic [3:0]          page_en,
  input logic                wide_sp_en,
  input logic                gpr_en,
  input logic                ext_en,
  input logic [EXT_AW-1:0]   ext_addr,
  input logic [4*PAGE_W-1:0] page_bank,
  input logic [15:0]         sp_val
);
  logic low_area, win_area;
  assign low_area = acc_addr < AW'(32);
  assign win_area = acc_addr >= AW'('h58) && acc_addr <= AW'('h5F);

  // R1
  gpr_route_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && low_area |-> gpr_en && !ext_en);

  // R9
  ext_route_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !low_area && !win_area |-> ext_en && !gpr_en &&
      ext_addr == EXT_AW'(DATA_BASE) + EXT_AW'(acc_addr));

  // R4
  page0_drop_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_we && acc_addr == AW'('h58) && !page_en[0]
      |=> $stable(page_bank[PAGE_W-1:0]));

  // R3
  page0_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    page_bank[PAGE_W-9:0] == '0);

  // R6
  sp_lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_we && acc_addr == AW'('h5D) |=> $stable(sp_val[15:8]));

  // R7
  sp_hi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_we && acc_addr == AW'('h5E) && !wide_sp_en |=> $stable(sp_val));

  // R11
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_we |=> rd_valid);

  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_we) |=> !rd_valid);
endmodule

bind core_reg_mapper cmap_chk #(
  .AW(AW), .EXT_AW(EXT_AW), .PAGE_W(PAGE_W), .DATA_BASE(DATA_BASE)
) u_chk (.*);

// File: tb/sim_core_reg_mapper.sv
module sim_core_reg_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [3:0]  page_en = 4'b0101;
  logic        wide_sp_en = 1'b0;
  logic        gpr_en, gpr_we;
  logic [4:0]  gpr_addr;
  logic [7:0]  gpr_wdata;
  logic [7:0]  gpr_rdata;
  logic        ext_en, ext_we;
  logic [23:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata;
  logic [95:0] page_bank;
  logic [23:0] jump_ext;
  logic [15:0] sp_val;
  logic [7:0]  status_flags;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  core_reg_mapper u0 (.*);

  // register file and external memory models, one-cycle read
  logic [7:0] rf  [32];
  logic [7:0] xm  [256];
  always @(posedge clk) begin
    if (gpr_en) begin
      if (gpr_we) rf[gpr_addr] <= gpr_wdata;
      gpr_rdata <= rf[gpr_addr];
    end
    if (ext_en) begin
      if (ext_we) xm[ext_addr[7:0]] <= ext_wdata;
      ext_rdata <= xm[ext_addr[7:0]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample result one cycle later
  task automatic acc(input logic we, input logic [15:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic rv);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    rd = rd_data; rv = rd_valid;
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 rd_valid", 32'(rd_valid), 0);
    chk("R10 sp", 32'(sp_val), 0);
    chk("R10 status", 32'(status_flags), 0);
    chk("R10 pages", 32'(page_bank != '0), 0);
    chk("R10 jump", 32'(jump_ext), 0);
  endtask

  task automatic t_gpr();
    logic [7:0] r; logic v;
    @(negedge clk);
    acc_valid = 1; acc_we = 1; acc_addr = 16'd31; acc_wdata = 8'hEE;
    #1;
    chk("R1 gpr_en", 32'(gpr_en), 1);
    chk("R1 ext_en", 32'(ext_en), 0);
    chk("R1 gpr_addr", 32'(gpr_addr), 31);
    chk("R1 gpr_we", 32'(gpr_we), 1);
    @(negedge clk); acc_valid = 0;
    chk("R11 no strobe after store", 32'(rd_valid), 0);
    acc(1, 16'd5, 8'h11, r, v);
    acc(0, 16'd31, 8'h00, r, v);
    chk("R2 read r31", 32'(r), 32'hEE);
    chk("R11 strobe", 32'(v), 1);
    acc(0, 16'd5, 8'h00, r, v);
    chk("R2 read r5", 32'(r), 32'h11);
    @(negedge clk);
    chk("R11 strobe drops", 32'(rd_valid), 0);
  endtask

  task automatic t_pages();
    logic [7:0] r; logic v;
    acc(1, 16'h58, 8'hA5, r, v);
    chk("R3 page0 value", 32'(page_bank[23:0]), 32'hA50000);
    acc(0, 16'h58, 8'h00, r, v);
    chk("R3 page0 read", 32'(r), 32'hA5);
    acc(1, 16'h59, 8'h3C, r, v);
    chk("R4 page1 dropped", 32'(page_bank[47:24]), 0);
    acc(0, 16'h59, 8'h00, r, v);
    chk("R4 page1 read", 32'(r), 0);
    page_en = 4'b1111;
    acc(1, 16'h59, 8'h3C, r, v);
    chk("R3 page1 enabled", 32'(page_bank[47:24]), 32'h3C0000);
    acc(1, 16'h5B, 8'h7E, r, v);
    acc(0, 16'h5B, 8'h00, r, v);
    chk("R3 page3 read", 32'(r), 32'h7E);
    page_en = 4'b0000;
    acc(1, 16'h5B, 8'h01, r, v);
    chk("R4 page3 kept", 32'(page_bank[95:72]), 32'h7E0000);
  endtask

  task automatic t_jump();
    logic [7:0] r; logic v;
    acc(1, 16'h5C, 8'h9B, r, v);
    chk("R5 jump value", 32'(jump_ext), 32'h9B0000);
    acc(0, 16'h5C, 8'h00, r, v);
    chk("R5 jump read", 32'(r), 32'h9B);
  endtask

  task automatic t_sp();
    logic [7:0] r; logic v;
    wide_sp_en = 0;
    acc(1, 16'h5D, 8'h34, r, v);
    chk("R6 sp low", 32'(sp_val), 32'h0034);
    acc(1, 16'h5E, 8'h12, r, v);
    chk("R7 sp high dropped", 32'(sp_val), 32'h0034);
    wide_sp_en = 1;
    acc(1, 16'h5E, 8'h12, r, v);
    chk("R7 sp high written", 32'(sp_val), 32'h1234);
    acc(1, 16'h5D, 8'h78, r, v);
    chk("R6 sp high kept", 32'(sp_val), 32'h1278);
    acc(0, 16'h5E, 8'h00, r, v);
    chk("R7 sp high read", 32'(r), 32'h12);
    acc(0, 16'h5D, 8'h00, r, v);
    chk("R7 sp low read", 32'(r), 32'h78);
  endtask

  task automatic t_status();
    logic [7:0] r; logic v;
    acc(1, 16'h5F, 8'h96, r, v);
    chk("R8 flags", 32'(status_flags), 32'h96);
    acc(0, 16'h5F, 8'h00, r, v);
    chk("R8 flags read", 32'(r), 32'h96);
  endtask

  task automatic t_ext();
    logic [7:0] r; logic v;
    @(negedge clk);
    acc_valid = 1; acc_we = 1; acc_addr = 16'h20; acc_wdata = 8'h42;
    #1;
    chk("R9 ext_en at 0x20", 32'(ext_en), 1);
    chk("R9 gpr_en at 0x20", 32'(gpr_en), 0);
    chk("R9 ext_addr 0x20", 32'(ext_addr), 32'h010020);
    @(negedge clk); acc_valid = 0;
    acc(1, 16'h57, 8'h57, r, v);
    acc(1, 16'h60, 8'h60, r, v);
    acc(0, 16'h20, 8'h00, r, v);
    chk("R9 read 0x20", 32'(r), 32'h42);
    acc(0, 16'h57, 8'h00, r, v);
    chk("R9 read 0x57", 32'(r), 32'h57);
    acc(0, 16'h60, 8'h00, r, v);
    chk("R9 read 0x60", 32'(r), 32'h60);
    chk("R11 strobe ext", 32'(v), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_gpr();
    t_pages();
    t_jump();
    t_sp();
    t_status();
    t_ext();
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule